// File: doc/BRIEF.md
# Directory-Coherent Cache Line Controller

This block tracks the coherence state of one processor cache line in a system where a home directory, not a shared bus, keeps caches consistent. The line is Invalid, Shared or Exclusive, and the block keeps the tag of the block it currently holds. Processor reads and writes arrive with an address, and the controller works out hit or miss itself by comparing the address with its tag. Every cache miss, every write to a Shared line, and every write-back becomes a point-to-point request to the home directory on a valid/ready message port.

The directory talks back with four commands addressed to a block: invalidate, fetch (return the dirty data and keep a read-only copy), fetch-and-invalidate (return the data and drop the line), and the data reply that completes an outstanding miss. After it sends a miss request, the controller waits and takes no new processor request until the data reply arrives. It then installs the new tag and state and pulses a completion signal to the processor. When a miss to another block hits an Exclusive line, the controller first writes the dirty victim back and only then asks for the new block.

Top module: `dir_cache_line_ctrl`

## Requirements
- R1: After reset the line is Invalid (line_state 0), out_valid is low, and cpu_req_ready is high while no directory message is present.
- R2: A read that misses (line Invalid, or a tag that differs) is accepted and followed, from the next cycle, by an outgoing read-miss message (out_kind 0) carrying the requested address. The data reply (net_in_kind 3) then makes the line Shared (line_state 1) with that address as tag.
- R3: A write to an Invalid line, or a write that hits a Shared line, sends a write-miss message (out_kind 1) with the request address. The data reply then makes the line Exclusive (line_state 2). The line enters Exclusive in no other way.
- R4: A read that hits a Shared or Exclusive line, and a write that hits an Exclusive line, send no message, leave the state unchanged, and raise cpu_done for one cycle, in the cycle after acceptance.
- R5: An invalidate (net_in_kind 0) whose address matches the tag of a Shared line, received while the controller is idle, makes the line Invalid in the next cycle.
- R6: A fetch (net_in_kind 1) that matches an Exclusive line sends a write-back (out_kind 2) carrying the tag. When that message is taken, the line becomes Shared.
- R7: A fetch-and-invalidate (net_in_kind 2) that matches an Exclusive line sends a write-back carrying the tag. When that message is taken, the line becomes Invalid.
- R8: A read or write that misses an Exclusive line first sends a write-back of the old tag and marks the line Invalid once that is taken. It then sends the read-miss or write-miss for the new address.
- R9: From the moment a miss is accepted until its data reply arrives, cpu_req_ready stays low, cpu_done stays low, and invalidates are ignored. A data reply that arrives when no miss is outstanding is ignored.
- R10: While out_valid is high and out_ready is low, out_valid, out_kind and out_addr hold their values.
- R11: A directory message takes precedence over a processor request in the same cycle, because cpu_req_ready is low whenever net_in_valid is high. A message whose address does not match the tag, or that does not apply to the current state (an invalidate to an Exclusive line, a fetch to a Shared line), changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Block address of the request |
| cpu_req_ready | output | 1 | Request accepted on this edge when valid |
| cpu_done | output | 1 | One-cycle completion pulse to the processor |
| net_in_valid | input | 1 | Directory message present (always consumed) |
| net_in_kind | input | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| net_in_addr | input | ADDR_W | Block address of the directory message |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Interconnect takes the message on this edge |
| out_kind | output | 2 | 0 read miss, 1 write miss, 2 data write-back |
| out_addr | output | ADDR_W | Block address of the outgoing message |
| line_state | output | 2 | 0 Invalid, 1 Shared, 2 Exclusive |

## Verification
A request accepted on an edge shows its message on the port in the cycle right after that edge, or raises cpu_done in that cycle for a hit. A state change caused by a directory command, a handshake or a data reply is visible one edge after the event. The bench holds a queue-based model that updates on each rising edge from the inputs driven at the previous falling edge. Five nanoseconds after every rising edge it compares all outputs with the model. Directed checks sample at falling edges, one edge after the stimulus, which is exactly where each result above is due.

// File: rtl/coh_pkg.sv
// Shared types for the directory-coherent cache line controller.
// Encodings are visible at the ports and must not be reordered.
package coh_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } ln_state_t;

    typedef enum logic [1:0] {
        IN_INVAL     = 2'd0,
        IN_FETCH     = 2'd1,
        IN_FETCH_INV = 2'd2,
        IN_REPLY     = 2'd3
    } in_msg_t;

    typedef enum logic [1:0] {
        OUT_RD_MISS = 2'd0,
        OUT_WR_MISS = 2'd1,
        OUT_WRBACK  = 2'd2
    } out_msg_t;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_EVICT = 3'd1,
        PH_MISS  = 3'd2,
        PH_WAIT  = 3'd3,
        PH_RESP  = 3'd4
    } phase_t;

endpackage

// File: rtl/dir_line_store.sv
// Holds the stable coherence state and the tag of the cached block.
// Assumes the sequencer raises at most one update per cycle; the tag
// changes only when a data reply installs a new block.
module dir_line_store
    import coh_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  ln_state_t         upd_state,
    input  logic              tag_en,
    input  logic [ADDR_W-1:0] tag_val,
    output ln_state_t         ln_st,
    output logic [ADDR_W-1:0] ln_tag
);

    // Register state and tag, cleared to Invalid/zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_st  <= LN_INV;
            ln_tag <= '0;
        end else begin
            if (upd_en) ln_st <= upd_state;
            if (tag_en) ln_tag <= tag_val;
        end
    end

endmodule

// File: rtl/dir_line_seq.sv
// Transaction sequencer: accepts processor requests and directory
// commands while idle, steps through write-back, miss and wait phases,
// and issues state/tag updates to the line store. It assumes directory
// messages are always consumed and that the interconnect drains the
// outgoing port eventually.
module dir_line_seq
    import coh_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_req_ready,
    output logic              cpu_done,
    input  logic              net_in_valid,
    input  in_msg_t           net_kind,
    input  logic [ADDR_W-1:0] net_in_addr,
    input  logic              out_ready,
    input  ln_state_t         ln_st,
    input  logic [ADDR_W-1:0] ln_tag,
    output phase_t            phase,
    output logic              req_wr,
    output logic [ADDR_W-1:0] req_addr,
    output logic              upd_en,
    output ln_state_t         upd_state,
    output logic              tag_en,
    output logic [ADDR_W-1:0] tag_val
);

    phase_t phase_n;
    logic   resp_inv, resp_inv_n;
    logic   done_n;
    logic   capture;
    logic   accept;
    logic   cpu_hit;
    logic   net_match;
    logic   got_reply;

    // Request handshake, hit detection and directory address match.
    assign cpu_req_ready = (phase == PH_IDLE) && !net_in_valid;
    assign accept        = cpu_req_valid && cpu_req_ready;
    assign cpu_hit       = (ln_st != LN_INV) && (cpu_req_addr == ln_tag);
    assign net_match     = (net_in_addr == ln_tag);
    assign got_reply     = net_in_valid && (net_kind == IN_REPLY);
    assign tag_val       = req_addr;

    // Next phase, completion pulse and store updates for this cycle.
    always_comb begin
        phase_n    = phase;
        resp_inv_n = resp_inv;
        upd_en     = 1'b0;
        upd_state  = ln_st;
        tag_en     = 1'b0;
        done_n     = 1'b0;
        capture    = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (net_in_valid) begin
                    if (net_match) begin
                        if (net_kind == IN_INVAL && ln_st == LN_SHR) begin
                            upd_en    = 1'b1;
                            upd_state = LN_INV;
                        end else if (net_kind == IN_FETCH && ln_st == LN_EXC) begin
                            phase_n    = PH_RESP;
                            resp_inv_n = 1'b0;
                        end else if (net_kind == IN_FETCH_INV && ln_st == LN_EXC) begin
                            phase_n    = PH_RESP;
                            resp_inv_n = 1'b1;
                        end
                    end
                end else if (accept) begin
                    if (cpu_hit && (!cpu_req_write || ln_st == LN_EXC)) begin
                        done_n = 1'b1;
                    end else begin
                        capture = 1'b1;
                        phase_n = (!cpu_hit && ln_st == LN_EXC) ? PH_EVICT : PH_MISS;
                    end
                end
            end
            PH_EVICT: begin
                if (out_ready) begin
                    upd_en    = 1'b1;
                    upd_state = LN_INV;
                    phase_n   = PH_MISS;
                end
            end
            PH_MISS: begin
                if (out_ready) phase_n = PH_WAIT;
            end
            PH_WAIT: begin
                if (got_reply) begin
                    upd_en    = 1'b1;
                    upd_state = req_wr ? LN_EXC : LN_SHR;
                    tag_en    = 1'b1;
                    done_n    = 1'b1;
                    phase_n   = PH_IDLE;
                end
            end
            PH_RESP: begin
                if (out_ready) begin
                    upd_en    = 1'b1;
                    upd_state = resp_inv ? LN_INV : LN_SHR;
                    phase_n   = PH_IDLE;
                end
            end
            default: phase_n = PH_IDLE;
        endcase
    end

    // Register phase, captured request, response flavour and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            req_wr   <= 1'b0;
            req_addr <= '0;
            resp_inv <= 1'b0;
            cpu_done <= 1'b0;
        end else begin
            phase    <= phase_n;
            resp_inv <= resp_inv_n;
            cpu_done <= done_n;
            if (capture) begin
                req_wr   <= cpu_req_write;
                req_addr <= cpu_req_addr;
            end
        end
    end

    // R5
    inval_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && net_in_valid && net_kind == IN_INVAL
         && net_in_addr == ln_tag && ln_st == LN_SHR) |=> (ln_st == LN_INV));

    // R9
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> $past(accept || (phase == PH_WAIT && got_reply)));

endmodule

// File: rtl/dir_msg_out.sv
// Outgoing message port: presents the message implied by the current
// phase. It assumes the sequencer keeps the phase, the captured request
// and the tag steady until out_ready, so the message holds on its own.
module dir_msg_out
    import coh_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  phase_t            phase,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] ln_tag,
    output logic              out_valid,
    output out_msg_t          out_kind,
    output logic [ADDR_W-1:0] out_addr
);

    // Select kind and address from the phase.
    always_comb begin
        out_valid = 1'b0;
        out_kind  = OUT_WRBACK;
        out_addr  = ln_tag;
        case (phase)
            PH_EVICT, PH_RESP: out_valid = 1'b1;
            PH_MISS: begin
                out_valid = 1'b1;
                out_kind  = req_wr ? OUT_WR_MISS : OUT_RD_MISS;
                out_addr  = req_addr;
            end
            default: out_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/dir_cache_line_ctrl.sv
// Cache-side coherence controller for one line in a directory-based
// system. Ties the sequencer, the line store and the outgoing message
// port together. It assumes directory messages address this line by
// block address, and that the processor side holds a request until it
// is accepted.
module dir_cache_line_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_req_ready,
    output logic              cpu_done,
    input  logic              net_in_valid,
    input  logic [1:0]        net_in_kind,
    input  logic [ADDR_W-1:0] net_in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_kind,
    output logic [ADDR_W-1:0] out_addr,
    output logic [1:0]        line_state
);

    ln_state_t         ln_st;
    logic [ADDR_W-1:0] ln_tag;
    phase_t            phase;
    logic              req_wr;
    logic [ADDR_W-1:0] req_addr;
    logic              upd_en;
    ln_state_t         upd_state;
    logic              tag_en;
    logic [ADDR_W-1:0] tag_val;
    out_msg_t          out_kind_e;
    in_msg_t           net_kind_e;

    // Decode the incoming kind and drive the plain output ports.
    assign net_kind_e = in_msg_t'(net_in_kind);
    assign out_kind   = out_kind_e;
    assign line_state = ln_st;

    dir_line_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_write (cpu_req_write),
        .cpu_req_addr  (cpu_req_addr),
        .cpu_req_ready (cpu_req_ready),
        .cpu_done      (cpu_done),
        .net_in_valid  (net_in_valid),
        .net_kind      (net_kind_e),
        .net_in_addr   (net_in_addr),
        .out_ready     (out_ready),
        .ln_st         (ln_st),
        .ln_tag        (ln_tag),
        .phase         (phase),
        .req_wr        (req_wr),
        .req_addr      (req_addr),
        .upd_en        (upd_en),
        .upd_state     (upd_state),
        .tag_en        (tag_en),
        .tag_val       (tag_val)
    );

    dir_line_store #(.ADDR_W(ADDR_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (upd_en),
        .upd_state (upd_state),
        .tag_en    (tag_en),
        .tag_val   (tag_val),
        .ln_st     (ln_st),
        .ln_tag    (ln_tag)
    );

    dir_msg_out #(.ADDR_W(ADDR_W)) msg_i (
        .phase     (phase),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .ln_tag    (ln_tag),
        .out_valid (out_valid),
        .out_kind  (out_kind_e),
        .out_addr  (out_addr)
    );

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_kind) && $stable(out_addr)));

    // R3
    excl_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_st == LN_EXC && $past(ln_st) != LN_EXC) |->
            $past(net_in_valid && net_kind_e == IN_REPLY));

    // R6
    fetch_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && net_in_valid && net_kind_e == IN_FETCH
         && net_in_addr == ln_tag && ln_st == LN_EXC) |=>
            (out_valid && out_kind_e == OUT_WRBACK && out_addr == $past(ln_tag)));

    // R8
    evict_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EVICT && out_ready) |=>
            (out_valid && out_kind_e != OUT_WRBACK && ln_st == LN_INV));

endmodule

// File: tb/dir_cache_line_ctrl_tb.sv
// Bench: queue-based behavioural model compared after every rising edge,
// plus directed checks sampled at falling edges.
module dir_cache_line_ctrl_tb_top;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_v, cpu_wr;
    logic [AW-1:0] cpu_a;
    logic          cpu_rdy, cpu_done;
    logic          net_v;
    logic [1:0]    net_k;
    logic [AW-1:0] net_a;
    logic          out_v, out_rdy;
    logic [1:0]    out_k;
    logic [AW-1:0] out_a;
    logic [1:0]    ln_st;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string cur = "R1";

    always #10 clk = ~clk;

    dir_cache_line_ctrl #(.ADDR_W(AW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_v),
        .cpu_req_write (cpu_wr),
        .cpu_req_addr  (cpu_a),
        .cpu_req_ready (cpu_rdy),
        .cpu_done      (cpu_done),
        .net_in_valid  (net_v),
        .net_in_kind   (net_k),
        .net_in_addr   (net_a),
        .out_valid     (out_v),
        .out_ready     (out_rdy),
        .out_kind      (out_k),
        .out_addr      (out_a),
        .line_state    (ln_st)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_st, m_tag, m_after, m_addr, pk;
    int q_k[$];
    int q_a[$];
    bit m_wait, m_wr, m_done, hit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_tag = 0; m_after = 0; m_wait = 0; m_done = 0;
            m_wr = 0; m_addr = 0;
            q_k.delete(); q_a.delete();
        end else begin
            m_done = 0;
            if (q_k.size() > 0) begin
                if (out_rdy) begin
                    pk = q_k.pop_front();
                    void'(q_a.pop_front());
                    if (pk == 2 && m_after == 1) m_st = 0;
                    if (q_k.size() == 0) begin
                        if (m_after == 1) m_wait = 1;
                        else if (m_after == 2) m_st = 1;
                        else if (m_after == 3) m_st = 0;
                    end
                end
            end else if (m_wait) begin
                if (net_v && net_k == 3) begin
                    m_st = m_wr ? 2 : 1;
                    m_tag = m_addr;
                    m_wait = 0;
                    m_done = 1;
                end
            end else if (net_v) begin
                if (int'(net_a) == m_tag) begin
                    if (net_k == 0 && m_st == 1) m_st = 0;
                    else if ((net_k == 1 || net_k == 2) && m_st == 2) begin
                        q_k.push_back(2); q_a.push_back(m_tag);
                        m_after = (net_k == 1) ? 2 : 3;
                    end
                end
            end else if (cpu_v) begin
                hit = (m_st != 0) && (int'(cpu_a) == m_tag);
                if (hit && (!cpu_wr || m_st == 2)) m_done = 1;
                else begin
                    if (!hit && m_st == 2) begin
                        q_k.push_back(2); q_a.push_back(m_tag);
                    end
                    q_k.push_back(cpu_wr ? 1 : 0); q_a.push_back(int'(cpu_a));
                    m_after = 1; m_wr = cpu_wr; m_addr = int'(cpu_a);
                end
            end
        end
    end

    // Compare every output with the model after each rising edge.
    always @(posedge clk) begin
        #5;
        if (rst_n && !finished) begin
            chk(cur, "model out_valid", int'(out_v), int'(q_k.size() > 0));
            if (q_k.size() > 0 && out_v) begin
                chk(cur, "model out_kind", int'(out_k), q_k[0]);
                chk(cur, "model out_addr", int'(out_a), q_a[0]);
            end
            chk(cur, "model line_state", int'(ln_st), m_st);
            chk(cur, "model cpu_done", int'(cpu_done), int'(m_done));
            chk(cur, "model cpu_req_ready", int'(cpu_rdy),
                int'(!(q_k.size() > 0 || m_wait) && !net_v));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cpu_op(bit wr, int a);
        cpu_v = 1'b1; cpu_wr = wr; cpu_a = AW'(a);
        #1;
        while (!cpu_rdy) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        cpu_v = 1'b0;
    endtask

    task automatic net_msg(int k, int a);
        net_v = 1'b1; net_k = 2'(k); net_a = AW'(a);
        @(negedge clk);
        net_v = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; cpu_v = 0; cpu_wr = 0; cpu_a = '0;
        net_v = 0; net_k = '0; net_a = '0; out_rdy = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur = "R1";
        chk("R1", "line_state", int'(ln_st), 0);
        chk("R1", "out_valid", int'(out_v), 0);
        chk("R1", "cpu_req_ready", int'(cpu_rdy), 1);

        cur = "R2";
        cpu_op(0, 'h12);
        chk("R2", "out_valid", int'(out_v), 1);
        chk("R2", "out_kind", int'(out_k), 0);
        chk("R2", "out_addr", int'(out_a), 'h12);
        idle(3);
        cur = "R9";
        cpu_v = 1'b1; cpu_wr = 1'b0; cpu_a = AW'('h12);
        #1;
        chk("R9", "ready while pending", int'(cpu_rdy), 0);
        net_msg(0, 'h12);
        cpu_v = 1'b0;
        chk("R9", "state while pending", int'(ln_st), 0);
        chk("R9", "done while pending", int'(cpu_done), 0);
        cur = "R2";
        net_msg(3, 0);
        chk("R2", "state after reply", int'(ln_st), 1);
        chk("R2", "done after reply", int'(cpu_done), 1);

        cur = "R4";
        cpu_op(0, 'h12);
        chk("R4", "read hit S done", int'(cpu_done), 1);
        chk("R4", "read hit S no msg", int'(out_v), 0);

        cur = "R3";
        cpu_op(1, 'h12);
        chk("R3", "write S out_kind", int'(out_k), 1);
        chk("R3", "write S out_addr", int'(out_a), 'h12);
        idle(3);
        net_msg(3, 0);
        chk("R3", "state after reply", int'(ln_st), 2);

        cur = "R4";
        cpu_op(1, 'h12);
        chk("R4", "write hit E done", int'(cpu_done), 1);
        chk("R4", "write hit E state", int'(ln_st), 2);
        cpu_op(0, 'h12);
        chk("R4", "read hit E done", int'(cpu_done), 1);
        chk("R4", "read hit E no msg", int'(out_v), 0);

        cur = "R11";
        net_msg(0, 'h12);
        chk("R11", "inval in E ignored", int'(ln_st), 2);
        net_msg(1, 'h55);
        chk("R11", "fetch mismatch no msg", int'(out_v), 0);
        chk("R11", "fetch mismatch state", int'(ln_st), 2);
        net_v = 1'b1; net_k = 2'd0; net_a = AW'('h99);
        cpu_v = 1'b1; cpu_wr = 1'b0; cpu_a = AW'('h12);
        #1;
        chk("R11", "ready with net msg", int'(cpu_rdy), 0);
        @(negedge clk);
        net_v = 1'b0;
        @(negedge clk);
        cpu_v = 1'b0;
        chk("R11", "deferred request done", int'(cpu_done), 1);

        cur = "R6";
        out_rdy = 1'b0;
        net_msg(1, 'h12);
        chk("R6", "fetch out_kind", int'(out_k), 2);
        chk("R6", "fetch out_addr", int'(out_a), 'h12);
        cur = "R10";
        idle(2);
        chk("R10", "held valid", int'(out_v), 1);
        chk("R10", "held kind", int'(out_k), 2);
        chk("R10", "held addr", int'(out_a), 'h12);
        out_rdy = 1'b1;
        cur = "R6";
        @(negedge clk);
        chk("R6", "state after fetch", int'(ln_st), 1);
        chk("R6", "port drained", int'(out_v), 0);

        cur = "R5";
        net_msg(0, 'h12);
        chk("R5", "state after inval", int'(ln_st), 0);

        cur = "R3";
        cpu_op(1, 'h20);
        chk("R3", "write I out_kind", int'(out_k), 1);
        idle(3);
        net_msg(3, 0);
        chk("R3", "state after reply", int'(ln_st), 2);

        cur = "R8";
        out_rdy = 1'b0;
        cpu_op(0, 'h30);
        chk("R8", "victim kind", int'(out_k), 2);
        chk("R8", "victim addr", int'(out_a), 'h20);
        out_rdy = 1'b1;
        @(negedge clk);
        chk("R8", "miss after wb kind", int'(out_k), 0);
        chk("R8", "miss after wb addr", int'(out_a), 'h30);
        chk("R8", "state after wb", int'(ln_st), 0);
        idle(3);
        net_msg(3, 0);
        chk("R8", "state after reply", int'(ln_st), 1);

        cur = "R7";
        cpu_op(1, 'h30);
        idle(3);
        net_msg(3, 0);
        chk("R7", "exclusive before", int'(ln_st), 2);
        net_msg(2, 'h30);
        chk("R7", "fetch-inv out_kind", int'(out_k), 2);
        chk("R7", "fetch-inv out_addr", int'(out_a), 'h30);
        @(negedge clk);
        chk("R7", "state after fetch-inv", int'(ln_st), 0);

        cur = "R9";
        net_msg(3, 0);
        chk("R9", "stray reply state", int'(ln_st), 0);
        chk("R9", "stray reply done", int'(cpu_done), 0);

        cur = "R8";
        cpu_op(1, 'h40);
        idle(3);
        net_msg(3, 0);
        cpu_op(1, 'h50);
        chk("R8", "write victim kind", int'(out_k), 2);
        chk("R8", "write victim addr", int'(out_a), 'h40);
        @(negedge clk);
        chk("R8", "write miss kind", int'(out_k), 1);
        chk("R8", "write miss addr", int'(out_a), 'h50);
        idle(3);
        net_msg(3, 0);
        chk("R8", "state after reply", int'(ln_st), 2);

        idle(2);
        summary();
    end

endmodule